// File: doc/BRIEF.md
# Dual-Register Input Capture Unit

This block watches an asynchronous timer input pin, brings it into the clock domain through a two-flop synchroniser and detects edges of a chosen polarity on the synchronised level. On each qualifying edge it stores the live value of an external running counter into one of two capture slots. The first capture goes into slot A and the second into slot B. Once both are filled, further edges are ignored until the capture count is restarted.

A one-cycle capture event is raised after the first capture or after the second, depending on a configuration bit. Deferring the event to the second edge lets software measure a period or a pulse width from two timestamps without reading anything between the edges. The count restarts when the status logic pulses a clear input, or when the capture mode leaves the off state. The counter, the interrupt status and the output pin driver sit outside this block.

Top module: `dual_capture_unit`

## Requirements
- R1: `cap_mode` selects edges: 0 = off (no capture), 1 = rising, 2 = falling, 3 = both edges.
- R2: A capture is taken only while `pin_is_input` is 1. With it at 0, qualifying edges leave both slots unchanged and raise no event.
- R3: The first capture after a restart writes `cap_slot_a`, and the second writes `cap_slot_b`. Edges after the second capture change neither slot until the count restarts.
- R4: `cap_event` is high for exactly the one cycle after a capture edge. With `event_on_second` = 0 it follows the first capture only. With 1 it follows the second capture only.
- R5: A high `count_clear` for one cycle restarts the count, so the next capture goes to slot A. If a capture edge falls in the same cycle, the restart wins and no capture is taken.
- R6: A change of `cap_mode` from 0 to any non-zero value restarts the count in the first cycle the new mode is seen.
- R7: After reset both slots read zero and `cap_event` is low. The slots have no write path other than captures.
- R8: The pin passes through two flops. A level applied before clock edge k is captured at edge k+2, together with the `counter_val` present in the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_async | input | 1 | Timer pin, asynchronous to clk |
| counter_val | input | CW | Live counter value to timestamp |
| cap_mode | input | 2 | Edge selection (R1 encoding) |
| pin_is_input | input | 1 | 1 when the pin is configured as an input |
| event_on_second | input | 1 | 0: event after the first capture, 1: event after the second |
| count_clear | input | 1 | One-cycle restart of the capture count |
| cap_slot_a | output | CW | First captured timestamp |
| cap_slot_b | output | CW | Second captured timestamp |
| cap_event | output | 1 | One-cycle capture event |

## Verification
The assertions assume that `count_clear` is a single-cycle pulse, and that the configuration inputs change only between pin transitions, not while an edge is moving through the synchroniser. The bench follows both rules. It changes the mode, direction and event-select inputs, and pulses the clear, only after the synchroniser has settled. The one exception is a directed case that lines a clear up with a capture edge on purpose. Random toggles keep the pin at one level long enough for every edge to be seen by itself.

// File: rtl/dcap_pkg.sv
package dcap_pkg;

  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;

  localparam int unsigned SLOTS = 2;
  localparam int unsigned IDXW  = $clog2(SLOTS);
  localparam int unsigned CNTW  = $clog2(SLOTS + 1);

  function automatic logic edge_hit(input cap_mode_e mode, input logic prev_lvl,
                                    input logic cur_lvl);
    unique case (mode)
      CAP_RISE: edge_hit = !prev_lvl && cur_lvl;
      CAP_FALL: edge_hit = prev_lvl && !cur_lvl;
      CAP_BOTH: edge_hit = prev_lvl ^ cur_lvl;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

  function automatic logic event_due(input logic [IDXW-1:0] slot_idx,
                                     input logic on_second);
    event_due = (slot_idx == (on_second ? IDXW'(SLOTS - 1) : IDXW'(0)));
  endfunction

endpackage

// File: rtl/dcap_sync.sv
module dcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic lvl_now,
  output logic lvl_prev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_async;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign lvl_now  = chain_q[STAGES-1];
  assign lvl_prev = prev_q;

  // R8: the sample one stage back becomes the previous sample next cycle
  assert_prev_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lvl_prev == $past(lvl_now));
endmodule

// File: rtl/dcap_edge.sv
module dcap_edge
  import dcap_pkg::*;
(
  input  cap_mode_e mode,
  input  logic      lvl_now,
  input  logic      lvl_prev,
  output logic      hit
);
  always_comb hit = edge_hit(mode, lvl_prev, lvl_now);
endmodule

// File: rtl/dcap_store.sv
module dcap_store
  import dcap_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  cap_mode_e     mode,
  input  logic          pin_is_input,
  input  logic          event_on_second,
  input  logic          count_clear,
  input  logic [CW-1:0] counter_val,
  output logic [CW-1:0] slot_a,
  output logic [CW-1:0] slot_b,
  output logic          cap_event,
  output logic          take,
  output logic          restart
);
  logic [CNTW-1:0] count_q;
  logic [CW-1:0]   slot_q [SLOTS];
  cap_mode_e       mode_q;
  logic            evt_q;
  logic            room;

  assign room    = (count_q < CNTW'(SLOTS));
  assign restart = count_clear || (mode_q == CAP_OFF && mode != CAP_OFF);
  assign take    = hit && pin_is_input && room && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      mode_q  <= CAP_OFF;
      evt_q   <= 1'b0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else begin
      mode_q <= mode;
      evt_q  <= 1'b0;
      if (restart) begin
        count_q <= '0;
      end else if (take) begin
        slot_q[count_q[IDXW-1:0]] <= counter_val;
        count_q <= count_q + 1'b1;
        evt_q   <= event_due(count_q[IDXW-1:0], event_on_second);
      end
    end
  end

  assign slot_a    = slot_q[0];
  assign slot_b    = slot_q[1];
  assign cap_event = evt_q;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNTW'(SLOTS));
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == CNTW'(SLOTS)) |=> $stable(slot_a) && $stable(slot_b));
  assert_output_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_is_input |=> $stable(slot_a) && $stable(slot_b) && !cap_event);
  assert_mode_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CAP_OFF) |=> $stable(slot_a) && $stable(slot_b) && !cap_event);
  assert_clear_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_clear |=> count_q == '0);
  assert_activate_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CAP_OFF && mode != CAP_OFF) |=> count_q == '0);
  assert_event_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |-> $past(take));
endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit
  import dcap_pkg::*;
#(
  parameter int unsigned CW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_async,
  input  logic [CW-1:0] counter_val,
  input  logic [1:0]    cap_mode,
  input  logic          pin_is_input,
  input  logic          event_on_second,
  input  logic          count_clear,
  output logic [CW-1:0] cap_slot_a,
  output logic [CW-1:0] cap_slot_b,
  output logic          cap_event
);
  logic      lvl_now, lvl_prev, hit, take, restart;
  cap_mode_e mode;

  assign mode = cap_mode_e'(cap_mode);

  dcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
    .lvl_now(lvl_now), .lvl_prev(lvl_prev));

  dcap_edge u_edge (
    .mode(mode), .lvl_now(lvl_now), .lvl_prev(lvl_prev), .hit(hit));

  dcap_store #(.CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .hit(hit), .mode(mode),
    .pin_is_input(pin_is_input), .event_on_second(event_on_second),
    .count_clear(count_clear), .counter_val(counter_val),
    .slot_a(cap_slot_a), .slot_b(cap_slot_b), .cap_event(cap_event),
    .take(take), .restart(restart));

  // R5: a restart cycle never stores a timestamp
  assert_restart_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !cap_event);
endmodule

// File: tb/test_dual_capture_unit.sv
module test_dual_capture_unit;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin_async = 1'b0;
  logic [CW-1:0] counter_val = '0;
  logic [1:0]    cap_mode = 2'd0;
  logic          pin_is_input = 1'b0;
  logic          event_on_second = 1'b0;
  logic          count_clear = 1'b0;
  logic [CW-1:0] cap_slot_a, cap_slot_b;
  logic          cap_event;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [CW-1:0] m_a = '0, m_b = '0;
  int            m_cnt = 0;
  logic          m_lvl = 1'b0;

  always #2.5 clk = ~clk;

  dual_capture_unit #(.CW(CW)) i_dual_capture_unit (
    .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .counter_val(counter_val),
    .cap_mode(cap_mode), .pin_is_input(pin_is_input),
    .event_on_second(event_on_second), .count_clear(count_clear),
    .cap_slot_a(cap_slot_a), .cap_slot_b(cap_slot_b), .cap_event(cap_event));

  function automatic logic qualifies(input logic [1:0] m, input logic o, input logic n);
    case (m)
      2'd1:    return (o == 1'b0) && (n == 1'b1);
      2'd2:    return (o == 1'b1) && (n == 1'b0);
      2'd3:    return o != n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp_evt);
    chk(req, cap_slot_a, m_a);
    chk(req, cap_slot_b, m_b);
    chk(req, {31'd0, cap_event}, {31'd0, exp_evt});
  endtask

  // drive a pin level and timestamp; the result shows two edges after the first sampling edge (R8)
  task automatic toggle(input logic lvl, input logic [CW-1:0] ts, input string req);
    logic hit, exp_evt;
    @(negedge clk);
    counter_val = ts;
    pin_async   = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    hit = qualifies(cap_mode, m_lvl, lvl);
    m_lvl = lvl;
    exp_evt = 1'b0;
    if (hit && pin_is_input && m_cnt < 2) begin
      if (m_cnt == 0) m_a = ts; else m_b = ts;
      exp_evt = (m_cnt == int'(event_on_second));
      m_cnt++;
    end
    check_all(req, exp_evt);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    if (cap_mode == 2'd0 && m != 2'd0) m_cnt = 0;
    cap_mode = m;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    count_clear = 1'b1;
    @(negedge clk);
    count_clear = 1'b0;
    m_cnt = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check_all("R7 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R7 after release", 1'b0);

    // R1 off mode ignores edges
    pin_is_input = 1'b1;
    toggle(1'b1, 32'h0000_0011, "R1 off");
    toggle(1'b0, 32'h0000_0012, "R1 off");

    // R1/R3/R4/R8 rising, event on first
    set_mode(2'd1);
    toggle(1'b1, 32'hAAAA_0001, "R8 R3 first capture R4 event first");
    toggle(1'b0, 32'hAAAA_0002, "R1 falling ignored in rising mode");
    toggle(1'b1, 32'hAAAA_0003, "R3 second capture R4 no event");
    toggle(1'b0, 32'hAAAA_0004, "R3 full");
    toggle(1'b1, 32'hAAAA_0005, "R3 further ignored");

    // R5 clear, event on second, falling mode
    pulse_clear();
    event_on_second = 1'b1;
    set_mode(2'd2);
    toggle(1'b0, 32'hBBBB_0001, "R5 restart R4 no event first");
    toggle(1'b1, 32'hBBBB_0002, "R1 rising ignored in falling mode");
    toggle(1'b0, 32'hBBBB_0003, "R4 event second");

    // R6 off to active restarts
    set_mode(2'd0);
    set_mode(2'd3);
    toggle(1'b1, 32'hCCCC_0001, "R6 restart both");
    toggle(1'b0, 32'hCCCC_0002, "R1 both R4 event second");

    // R2 output direction
    pulse_clear();
    pin_is_input = 1'b0;
    toggle(1'b1, 32'hDDDD_0001, "R2 output dir ignored");
    pin_is_input = 1'b1;
    toggle(1'b0, 32'hDDDD_0002, "R2 input again");

    // R5 clear coincides with capture edge: the restart wins
    pulse_clear();
    @(negedge clk);
    counter_val = 32'hEEEE_0001;
    pin_async = 1'b1;
    @(negedge clk);
    @(negedge clk);
    count_clear = 1'b1;
    @(negedge clk);
    count_clear = 1'b0;
    m_lvl = 1'b1;
    m_cnt = 0;
    check_all("R5 clear beats capture", 1'b0);
    toggle(1'b0, 32'hEEEE_0002, "R5 next goes to slot A");

    // random phase
    for (int it = 0; it < 300; it++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r == 0) pulse_clear();
      else if (r == 1) set_mode(2'($urandom_range(0, 3)));
      else if (r == 2) begin
        @(negedge clk);
        pin_is_input = 1'($urandom_range(0, 4) != 0);
        event_on_second = 1'($urandom_range(0, 1));
      end else toggle(~m_lvl, $urandom, "R3 R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule